// File: doc/BRIEF.md
# Fuse word lock bank

This block keeps the lock state that guards the words of a one-time-programmable fuse array. It holds four sticky per-word bitmaps: shadow-read lock, shadow-write lock, program lock and a permanent-record lock. Each bitmap is split into 32-bit banks on a simple register bus. A bus write can only set bits, and a bit clears only on reset. A global lock register sits beside them with three meaningful bits: upper-region lock, debug-configuration lock and program-all lock.

A query index is decoded combinationally into three permissions: may shadow, may write the shadow copy, and may program. A second index port answers whether a non-secure requester may reach that word. Words below a configurable upper-region base are always open. Words from the base upward need a grant bit, held in a fifth bitmap of the same write-1-to-set kind. That bitmap can no longer change once the upper-region lock is set. Indices past the last fuse word are refused on both ports. The fuse programming sequence itself lives elsewhere and only consumes these decisions.

Top module: `fuselock_bank`

## Requirements
- R1: After reset every lock bit, grant bit and global lock bit is 0, and every mapped register reads 0.
- R2: For word index i, the lock bit sits in bank i>>5 at bit i[4:0]. Bank b of a family is at byte address base+4*b. The family bases are 0x094 (shadow-read), 0x07C (shadow-write), 0x064 (program) and 0x04C (permanent). The grant bit of word i sits in the same way at index i-UPPER_BASE, with its banks starting at 0x0C0.
- R3: A bus write to a lock or grant bank ORs the written data into the bank. Zero bits leave the existing state unchanged, and a set bit reads back as 1.
- R4: Lock, grant and global bits never clear while reset is inactive, and all of them clear on reset.
- R5: The global lock register at 0x010 is write-1-to-set. Bit 0 is the upper-region lock, bit 2 the debug lock and bit 4 the program-all lock. Other bits ignore writes and read 0. Outputs glb_upper_lock and glb_dbg_lock show bits 0 and 2.
- R6: For an in-range q_idx: q_shadow_ok is the inverse of the shadow-read bit and q_write_ok is the inverse of the shadow-write bit. q_prog_ok is high only when the program bit, the permanent bit and the program-all lock are all clear.
- R7: A q_idx above NUM_WORDS-1 drives q_range_err high and all three permissions low. An ns_idx above NUM_WORDS-1 drives ns_allow low.
- R8: ns_allow is high for every ns_idx below UPPER_BASE, whatever the grant bits hold.
- R9: For UPPER_BASE <= ns_idx <= NUM_WORDS-1, ns_allow equals the grant bit of that word.
- R10: Writes to the grant banks have no effect while the upper-region lock is set.
- R11: Unmapped addresses, including bank slots past a family's last bank, read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (12) | Byte address of the register |
| bus_wdata | input | 32 | Write data, ones set bits |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| q_idx | input | IW (8) | Word index for the lock query |
| q_shadow_ok | output | 1 | Shadowing of q_idx permitted |
| q_write_ok | output | 1 | Writing the shadow of q_idx permitted |
| q_prog_ok | output | 1 | Programming q_idx permitted |
| q_range_err | output | 1 | q_idx beyond the last word |
| ns_idx | input | IW (8) | Word index for the non-secure access decision |
| ns_allow | output | 1 | Non-secure access to ns_idx permitted |
| glb_upper_lock | output | 1 | Upper-region global lock |
| glb_dbg_lock | output | 1 | Debug-configuration global lock |

## Verification
The hardest state to reach from the ports is a grant bitmap frozen by the upper-region lock. Only reset undoes that lock, so once it is set every later grant test sees a frozen bitmap. The stimulus therefore sets and checks all grants first. It then sets the global lock and shows that a further grant write is ignored on both the read-back and ns_allow. A final reset shows that every sticky bit returns to zero.

// File: rtl/fuselock_pkg.sv
package fuselock_pkg;

  localparam int NUM_FAM = 4;
  localparam int FAM_SRD  = 0;
  localparam int FAM_SWR  = 1;
  localparam int FAM_PRG  = 2;
  localparam int FAM_PERM = 3;

  localparam int GLB_ADDR  = 'h010;
  localparam int GRANT_BASE = 'h0C0;
  localparam logic [31:0] GLB_MASK = 32'h0000_0015;
  localparam int GLB_UPPER_BIT = 0;
  localparam int GLB_DBG_BIT   = 2;
  localparam int GLB_PROG_BIT  = 4;

  // byte offset of bank 0 for each lock family
  function automatic int family_base(input int fam);
    case (fam)
      FAM_SRD:  return 'h094;
      FAM_SWR:  return 'h07C;
      FAM_PRG:  return 'h064;
      default:  return 'h04C;
    endcase
  endfunction

  function automatic int bank_count(input int nbits);
    return (nbits + 31) / 32;
  endfunction

  // bits of bank b that map to a real word
  function automatic logic [31:0] bank_mask(input int nbits, input int b);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (b * 32 + i < nbits) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/fuselock_bitmap.sv
module fuselock_bitmap
  import fuselock_pkg::*;
#(
  parameter int NUM_BITS = 96,
  parameter int BASE     = 'h094,
  parameter int AW       = 12,
  parameter int IW       = 8,
  localparam int BANKS   = bank_count(NUM_BITS),
  localparam int PADW    = BANKS * 32,
  localparam int SW      = (PADW > 1) ? $clog2(PADW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  input  logic [IW-1:0]   qidx,
  output logic [31:0]     rdata,
  output logic            q_bit,
  output logic [PADW-1:0] map_o
);

  logic [PADW-1:0] map_q;
  logic [SW-1:0]   qsel;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [AW-1:0] BANK_ADDR = AW'(BASE + 4 * b);
    localparam logic [31:0]   VMASK     = bank_mask(NUM_BITS, b);
    logic sel;
    assign sel = (addr == BANK_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[b*32 +: 32] <= '0;
      end else if (wr_en && sel) begin
        map_q[b*32 +: 32] <= map_q[b*32 +: 32] | (wdata & VMASK);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == AW'(BASE + 4 * b)) rdata = map_q[b*32 +: 32];
    end
  end

  assign qsel  = qidx[SW-1:0];
  assign q_bit = (int'(qidx) < NUM_BITS) ? map_q[qsel] : 1'b0;
  assign map_o = map_q;

endmodule

// File: rtl/fuselock_global.sv
module fuselock_global
  import fuselock_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          upper_lock,
  output logic          dbg_lock,
  output logic          prog_lock,
  output logic [31:0]   glb_o
);

  logic [31:0] glb_q;
  logic        sel;

  assign sel = (addr == AW'(GLB_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= '0;
    end else if (wr_en && sel) begin
      glb_q <= glb_q | (wdata & GLB_MASK);
    end
  end

  assign rdata      = sel ? glb_q : '0;
  assign upper_lock = glb_q[GLB_UPPER_BIT];
  assign dbg_lock   = glb_q[GLB_DBG_BIT];
  assign prog_lock  = glb_q[GLB_PROG_BIT];
  assign glb_o      = glb_q;

endmodule

// File: rtl/fuselock_bank.sv
module fuselock_bank
  import fuselock_pkg::*;
#(
  parameter int NUM_WORDS  = 96,
  parameter int UPPER_BASE = 32,
  parameter int AW         = 12,
  parameter int IW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [IW-1:0] q_idx,
  output logic          q_shadow_ok,
  output logic          q_write_ok,
  output logic          q_prog_ok,
  output logic          q_range_err,
  input  logic [IW-1:0] ns_idx,
  output logic          ns_allow,
  output logic          glb_upper_lock,
  output logic          glb_dbg_lock
);

  localparam int UPPER_WORDS = NUM_WORDS - UPPER_BASE;
  localparam int FAM_PADW    = bank_count(NUM_WORDS) * 32;
  localparam int GNT_PADW    = bank_count(UPPER_WORDS) * 32;

  logic [NUM_FAM-1:0]          fam_bit;
  logic [NUM_FAM-1:0][31:0]    fam_rdata;
  logic [NUM_FAM*FAM_PADW-1:0] lock_state;
  logic [GNT_PADW-1:0]         grant_state;
  logic [31:0]                 grant_rdata;
  logic [31:0]                 glb_rdata;
  logic [31:0]                 glb_state;
  logic                        glb_prog_lock;
  logic                        grant_wr_en;
  logic                        grant_bit;
  logic [IW-1:0]               ns_off;
  logic                        q_in_range;
  logic                        ns_in_range;
  logic                        ns_lower;

  for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
    fuselock_bitmap #(
      .NUM_BITS (NUM_WORDS),
      .BASE     (family_base(f)),
      .AW       (AW),
      .IW       (IW)
    ) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_we),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .qidx  (q_idx),
      .rdata (fam_rdata[f]),
      .q_bit (fam_bit[f]),
      .map_o (lock_state[f*FAM_PADW +: FAM_PADW])
    );
  end

  assign grant_wr_en = bus_we & ~glb_upper_lock;
  assign ns_off      = ns_idx - IW'(UPPER_BASE);

  fuselock_bitmap #(
    .NUM_BITS (UPPER_WORDS),
    .BASE     (GRANT_BASE),
    .AW       (AW),
    .IW       (IW)
  ) u_grant (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (grant_wr_en),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .qidx  (ns_off),
    .rdata (grant_rdata),
    .q_bit (grant_bit),
    .map_o (grant_state)
  );

  fuselock_global #(.AW(AW)) u_glb (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (glb_rdata),
    .upper_lock (glb_upper_lock),
    .dbg_lock   (glb_dbg_lock),
    .prog_lock  (glb_prog_lock),
    .glb_o      (glb_state)
  );

  always_comb begin
    bus_rdata = glb_rdata | grant_rdata;
    for (int f = 0; f < NUM_FAM; f++) bus_rdata = bus_rdata | fam_rdata[f];
  end

  assign q_in_range  = int'(q_idx) < NUM_WORDS;
  assign q_range_err = ~q_in_range;
  assign q_shadow_ok = q_in_range & ~fam_bit[FAM_SRD];
  assign q_write_ok  = q_in_range & ~fam_bit[FAM_SWR];
  assign q_prog_ok   = q_in_range & ~fam_bit[FAM_PRG] & ~fam_bit[FAM_PERM]
                       & ~glb_prog_lock;

  assign ns_in_range = int'(ns_idx) < NUM_WORDS;
  assign ns_lower    = int'(ns_idx) < UPPER_BASE;
  assign ns_allow    = ns_in_range & (ns_lower | grant_bit);

endmodule

// File: rtl/fuselock_bank_chk.sv
module fuselock_bank_chk #(
  parameter int NUM_WORDS  = 96,
  parameter int UPPER_BASE = 32,
  parameter int IW         = 8,
  parameter int LW         = 384,
  parameter int GW         = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] lock_state,
  input logic [GW-1:0] grant_state,
  input logic [31:0]   glb_state,
  input logic          glb_upper_lock,
  input logic [IW-1:0] q_idx,
  input logic          q_shadow_ok,
  input logic          q_write_ok,
  input logic          q_prog_ok,
  input logic          q_range_err,
  input logic [IW-1:0] ns_idx,
  input logic          ns_allow
);

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_state) & ~lock_state) == '0));

  // R4
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(grant_state) & ~grant_state) == '0));

  // R5
  glb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(glb_state) & ~glb_state) == '0));

  // R5
  glb_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((glb_state & ~32'h15) == '0));

  // R7
  q_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_idx) >= NUM_WORDS) |-> (q_range_err && !q_shadow_ok && !q_write_ok && !q_prog_ok));

  // R7
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ns_idx) >= NUM_WORDS) |-> !ns_allow);

  // R8
  ns_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ns_idx) < UPPER_BASE) |-> ns_allow);

  // R10
  grant_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_upper_lock |=> $stable(grant_state));

endmodule

bind fuselock_bank fuselock_bank_chk #(
  .NUM_WORDS  (NUM_WORDS),
  .UPPER_BASE (UPPER_BASE),
  .IW         (IW),
  .LW         (NUM_FAM * FAM_PADW),
  .GW         (GNT_PADW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lock_state     (lock_state),
  .grant_state    (grant_state),
  .glb_state      (glb_state),
  .glb_upper_lock (glb_upper_lock),
  .q_idx          (q_idx),
  .q_shadow_ok    (q_shadow_ok),
  .q_write_ok     (q_write_ok),
  .q_prog_ok      (q_prog_ok),
  .q_range_err    (q_range_err),
  .ns_idx         (ns_idx),
  .ns_allow       (ns_allow)
);

// File: tb/fuselock_bank_test.sv
module fuselock_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  q_idx = '0;
  logic        q_shadow_ok, q_write_ok, q_prog_ok, q_range_err;
  logic [7:0]  ns_idx = '0;
  logic        ns_allow, glb_upper_lock, glb_dbg_lock;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fuselock_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .q_idx(q_idx),
    .q_shadow_ok(q_shadow_ok), .q_write_ok(q_write_ok), .q_prog_ok(q_prog_ok),
    .q_range_err(q_range_err), .ns_idx(ns_idx), .ns_allow(ns_allow),
    .glb_upper_lock(glb_upper_lock), .glb_dbg_lock(glb_dbg_lock)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  // {range_err, prog_ok, write_ok, shadow_ok}
  task automatic q_chk(input int idx, input logic [3:0] exp, input string tag);
    @(negedge clk);
    q_idx = 8'(idx);
    #1 check(tag, {28'b0, q_range_err, q_prog_ok, q_write_ok, q_shadow_ok}, {28'b0, exp});
  endtask

  task automatic ns_chk(input int idx, input logic exp, input string tag);
    @(negedge clk);
    ns_idx = 8'(idx);
    #1 check(tag, {31'b0, ns_allow}, {31'b0, exp});
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset(input string tag);
    int addrs[11] = '{'h094, 'h098, 'h09C, 'h07C, 'h084, 'h064, 'h04C, 'h054, 'h010, 'h0C0, 'h0C4};
    foreach (addrs[i]) rd_chk(12'(addrs[i]), 32'h0, tag);
    q_chk(5, 4'b0111, tag);
    q_chk(95, 4'b0111, tag);
    ns_chk(40, 1'b0, tag);
  endtask

  task automatic t_families;
    wr(12'h094, 32'h1 << 5);                 // word 5 shadow-read lock
    rd_chk(12'h094, 32'h20, "R3 readback");
    q_chk(5, 4'b0110, "R6 shadow lock word 5");
    q_chk(6, 4'b0111, "R2 neighbour word 6");
    wr(12'h098, 32'h1 << 3);                 // word 35
    q_chk(35, 4'b0110, "R2 bank1 word 35");
    q_chk(3, 4'b0111, "R2 word 3 unaffected");
    wr(12'h094, 32'h0);
    rd_chk(12'h094, 32'h20, "R3 zero write keeps bits");
    wr(12'h094, 32'h1);
    rd_chk(12'h094, 32'h21, "R3 OR into bank");
    wr(12'h084, 32'h8000_0000);              // word 95 shadow-write
    q_chk(95, 4'b0101, "R6 write lock word 95");
    wr(12'h068, 32'h1);                      // word 32 program
    q_chk(32, 4'b0011, "R6 program lock word 32");
    wr(12'h04C, 32'h1 << 7);                 // word 7 permanent
    q_chk(7, 4'b0011, "R6 permanent lock word 7");
    rd_chk(12'h04C, 32'h80, "R2 permanent bank0");
  endtask

  task automatic t_ns;
    ns_chk(10, 1'b1, "R8 lower word 10");
    ns_chk(31, 1'b1, "R8 lower word 31");
    ns_chk(32, 1'b0, "R9 word 32 no grant");
    wr(12'h0C0, 32'h1 << 8);                 // word 40
    rd_chk(12'h0C0, 32'h100, "R3 grant readback");
    ns_chk(40, 1'b1, "R9 word 40 granted");
    ns_chk(41, 1'b0, "R9 word 41 not granted");
    wr(12'h0C4, 32'h8000_0000);              // word 95
    ns_chk(95, 1'b1, "R9 word 95 granted");
  endtask

  task automatic t_range;
    q_chk(96, 4'b1000, "R7 q_idx 96");
    q_chk(255, 4'b1000, "R7 q_idx 255");
    ns_chk(96, 1'b0, "R7 ns_idx 96");
    ns_chk(200, 1'b0, "R7 ns_idx 200");
  endtask

  task automatic t_unmapped;
    wr(12'h0A0, 32'hFFFF_FFFF);
    rd_chk(12'h0A0, 32'h0, "R11 slot past last bank");
    rd_chk(12'h200, 32'h0, "R11 unmapped read");
    rd_chk(12'h094, 32'h21, "R11 neighbour unchanged");
    q_chk(10, 4'b0111, "R11 no lock from stray write");
  endtask

  task automatic t_global;
    check("R5 dbg lock clear", {31'b0, glb_dbg_lock}, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk(12'h010, 32'h15, "R5 sparse bits");
    check("R5 outputs", {30'b0, glb_upper_lock, glb_dbg_lock}, 32'h3);
    q_chk(10, 4'b0011, "R6 program-all lock");
    wr(12'h010, 32'h0);
    rd_chk(12'h010, 32'h15, "R4 global sticky");
    wr(12'h0C0, 32'h1 << 9);                 // word 41, must be ignored
    rd_chk(12'h0C0, 32'h100, "R10 grant frozen");
    ns_chk(41, 1'b0, "R10 word 41 still denied");
    ns_chk(40, 1'b1, "R4 grant kept");
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset("R1 reset state");
    t_families();
    t_ns();
    t_range();
    t_unmapped();
    t_global();
    do_reset();
    t_reset("R4 cleared by reset");
    check("R4 global cleared", {30'b0, glb_upper_lock, glb_dbg_lock}, 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule